// File: doc/BRIEF.md
# Serial Gain and Calibration Control Register

This block is the digital control front end of a programmable analog gain and filter stage. A mode strap decides how the serial port behaves. With the strap high, the port works as a simple serial write port. An 8-bit control word is clocked in on a serial clock while the select line is low. The word is held in a shift register and takes effect on the rising edge of the select line. The held word sets a 2-bit gain code, picks one of two stored configurations, and can ask for a calibration. With the strap low, the block ignores the serial lines and passes through the gain and configuration values that come from non-volatile storage.

The block also owns the calibration sequencer. After reset a power-up calibration runs by itself. Later calibrations start on a rising edge of a dedicated calibration pin, or when the calibration bit of the held word changes from 0 to 1. While a calibration is running, `cal_busy` is high, and the analog stage uses it to force its outputs to mid-supply. Both durations are parameters counted in clock cycles. All serial and pin inputs are asynchronous and pass through synchronizers inside the block.

Top module: `sgc_ctrl_reg`

## Requirements
- R1: While `spi_en` is high and `cs` is low, each rising edge of `sck` shifts one bit from `sdi` into the shift register. After eight edges, the first bit sent sits at bit 0 and the last at bit 7. The field positions are: bit 7 gain bit G0, bit 6 gain bit G1, bit 5 configuration select, bit 4 calibration bit, bits 3..0 padding.
- R2: With `spi_en` high, `gain_code` equals {G1, G0} of the held word. The codes are 00 for 1X, 01 for 2X, 10 for 5X and 11 for 10X.
- R3: After reset, both the shift register and the held word are all zeros. With `spi_en` high, the outputs then show `gain_code` 00 and `cfg_sel` 0.
- R4: The held word, and so `gain_code` and `cfg_sel`, changes only on a rising edge of `cs` while `spi_en` is high. Shifting alone does not change the outputs.
- R5: The four padding bits have no effect on any output.
- R6: With `spi_en` low, `gain_code` and `cfg_sel` follow `nv_gain` and `nv_sel`. Serial clocks and `cs` edges seen while `spi_en` is low leave the shift register and the held word unchanged.
- R7: From reset release, `cal_busy` is high for exactly PWRUP_CYCLES clock cycles.
- R8: When idle, a rising edge on `cal_pin` makes `cal_busy` high for exactly USER_CYCLES cycles.
- R9: When idle, latching a word whose calibration bit is 1 while the held calibration bit is 0 starts a USER_CYCLES calibration. Latching a calibration bit of 1 over a held 1 starts nothing.
- R10: A calibration request that arrives while `cal_busy` is high is ignored and does not extend the busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_en | input | 1 | Mode strap; high selects the serial write port |
| sck | input | 1 | Serial clock (asynchronous) |
| sdi | input | 1 | Serial data in (asynchronous) |
| cs | input | 1 | Select; low while shifting, rising edge latches |
| cal_pin | input | 1 | Calibration request pin, rising-edge active |
| nv_gain | input | 2 | Stored gain code used when the strap is low |
| nv_sel | input | 1 | Stored configuration select used when the strap is low |
| gain_code | output | 2 | Active gain code |
| cfg_sel | output | 1 | Active configuration select (0 = A, 1 = B) |
| cal_busy | output | 1 | Calibration running; analog outputs held at mid-supply |

## Verification
The assertions assume that `sck`, `sdi`, `cs` and `cal_pin` are slow compared with `clk`. Each level must stay steady for more cycles than the synchronizer depth, and `sdi` must settle before the `sck` edge that samples it. The stimulus holds every serial half-period and every calibration pulse for six or more clocks. It changes `sdi` only while `sck` is low and moves `cs` only while `sck` is idle. Calibration durations are shortened through the parameters so that whole busy windows can be counted cycle by cycle.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
    localparam int WORD_W = 8;
    localparam int PAD_W  = 4;

    typedef struct packed {
        logic             g0;
        logic             g1;
        logic             sel;
        logic             cal;
        logic [PAD_W-1:0] pad;
    } ctrl_word_t;

    typedef enum logic [1:0] {
        GAIN_X1  = 2'b00,
        GAIN_X2  = 2'b01,
        GAIN_X5  = 2'b10,
        GAIN_X10 = 2'b11
    } gain_e;

    function automatic gain_e gain_of(input ctrl_word_t w);
        return gain_e'({w.g1, w.g0});
    endfunction
endpackage

// File: rtl/sgc_sync.sv
module sgc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sgc_shift_hold.sv
module sgc_shift_hold
    import sgc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       sck_rise,
    input  logic       cs_lvl,
    input  logic       cs_rise,
    input  logic       sdi,
    output ctrl_word_t held,
    output logic       cal_req
);
    ctrl_word_t shreg;
    logic       do_shift, do_latch;

    assign do_shift = en && !cs_lvl && sck_rise;
    assign do_latch = en && cs_rise;

    always_ff @(posedge clk) begin
        if (rst)           shreg <= '0;
        else if (do_shift) shreg <= ctrl_word_t'({sdi, shreg[WORD_W-1:1]});
    end

    always_ff @(posedge clk) begin
        if (rst)           held <= '0;
        else if (do_latch) held <= shreg;
    end

    assign cal_req = do_latch && shreg.cal && !held.cal;

    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
        do_shift |=> shreg[WORD_W-2:0] == $past(shreg[WORD_W-1:1]))  // R1
        else $error("AST_SHIFT_RIGHT");
    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(shreg))  // R6
        else $error("AST_SHIFT_IDLE");
    AST_LATCH_COPY: assert property (@(posedge clk) disable iff (rst)
        do_latch |=> held == $past(shreg))  // R4
        else $error("AST_LATCH_COPY");
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !do_latch |=> $stable(held))  // R4
        else $error("AST_HELD_STABLE");
endmodule

// File: rtl/sgc_cal_timer.sv
module sgc_cal_timer #(
    parameter int PWRUP_CYCLES = 62_500_000,
    parameter int USER_CYCLES  = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_pin,
    input  logic trig_word,
    output logic busy
);
    localparam int MAXC = (PWRUP_CYCLES > USER_CYCLES) ? PWRUP_CYCLES : USER_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic          trig;

    assign trig = trig_pin || trig_word;
    assign busy = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= CW'(PWRUP_CYCLES);
        else if (busy) cnt <= cnt - CW'(1);
        else if (trig) cnt <= CW'(USER_CYCLES);
    end

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        busy |=> cnt == $past(cnt) - CW'(1))  // R10
        else $error("AST_COUNT_DOWN");
    AST_START_LEN: assert property (@(posedge clk) disable iff (rst)
        !busy && trig |=> cnt == CW'(USER_CYCLES))  // R8
        else $error("AST_START_LEN");
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !busy && !trig |=> !busy)  // R9
        else $error("AST_IDLE_HOLD");
endmodule

// File: rtl/sgc_ctrl_reg.sv
module sgc_ctrl_reg
    import sgc_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int PWRUP_CYCLES = 62_500_000,
    parameter int USER_CYCLES  = 25_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_en,
    input  logic       sck,
    input  logic       sdi,
    input  logic       cs,
    input  logic       cal_pin,
    input  logic [1:0] nv_gain,
    input  logic       nv_sel,
    output logic [1:0] gain_code,
    output logic       cfg_sel,
    output logic       cal_busy
);
    localparam int N_IN  = 4;
    localparam int I_SCK = 0;
    localparam int I_SDI = 1;
    localparam int I_CS  = 2;
    localparam int I_CAL = 3;

    logic [N_IN-1:0] raw_in, lvl;
    logic            sck_q, cs_q, cal_q;
    logic            sck_rise, cs_rise, cal_rise;
    ctrl_word_t      held;
    logic            cal_req;

    assign raw_in = {cal_pin, cs, sdi, sck};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        sgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw_in[g]),
            .q   (lvl[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b0;
            cal_q <= 1'b0;
        end else begin
            sck_q <= lvl[I_SCK];
            cs_q  <= lvl[I_CS];
            cal_q <= lvl[I_CAL];
        end
    end

    assign sck_rise = lvl[I_SCK] && !sck_q;
    assign cs_rise  = lvl[I_CS]  && !cs_q;
    assign cal_rise = lvl[I_CAL] && !cal_q;

    sgc_shift_hold u_shift (
        .clk      (clk),
        .rst      (rst),
        .en       (spi_en),
        .sck_rise (sck_rise),
        .cs_lvl   (lvl[I_CS]),
        .cs_rise  (cs_rise),
        .sdi      (lvl[I_SDI]),
        .held     (held),
        .cal_req  (cal_req)
    );

    sgc_cal_timer #(
        .PWRUP_CYCLES (PWRUP_CYCLES),
        .USER_CYCLES  (USER_CYCLES)
    ) u_cal (
        .clk       (clk),
        .rst       (rst),
        .trig_pin  (cal_rise),
        .trig_word (cal_req),
        .busy      (cal_busy)
    );

    always_comb begin
        if (spi_en) begin
            gain_code = gain_of(held);
            cfg_sel   = held.sel;
        end else begin
            gain_code = nv_gain;
            cfg_sel   = nv_sel;
        end
    end

    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_busy) |-> $past(cal_rise || cal_req))  // R8
        else $error("AST_BUSY_CAUSE");
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
        spi_en && $past(spi_en) && !$past(cs_rise) |-> $stable(gain_code) && $stable(cfg_sel))  // R4
        else $error("AST_OUT_STABLE");
endmodule

// File: tb/sgc_ctrl_reg_tb.sv
module sgc_ctrl_reg_tb_top;
    localparam int PWRUP = 40;
    localparam int USER  = 17;
    localparam int HALF  = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_en = 1'b1, sck = 1'b0, sdi = 1'b0, cs = 1'b1, cal_pin = 1'b0;
    logic [1:0] nv_gain = 2'b10;
    logic       nv_sel = 1'b1;
    logic [1:0] gain_code;
    logic       cfg_sel, cal_busy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sgc_ctrl_reg #(
        .SYNC_STAGES  (2),
        .PWRUP_CYCLES (PWRUP),
        .USER_CYCLES  (USER)
    ) dut_i (
        .clk(clk), .rst(rst), .spi_en(spi_en), .sck(sck), .sdi(sdi), .cs(cs),
        .cal_pin(cal_pin), .nv_gain(nv_gain), .nv_sel(nv_sel),
        .gain_code(gain_code), .cfg_sel(cfg_sel), .cal_busy(cal_busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_shift(input logic [7:0] w);
        @(negedge clk);
        cs = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 8; i++) begin
            sdi = w[i];
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
    endtask

    task automatic spi_latch();
        @(negedge clk);
        cs = 1'b1;
    endtask

    task automatic meas_busy(output int n);
        int t = 0;
        n = 0;
        while (!cal_busy && t < 30) begin
            @(negedge clk);
            t++;
        end
        while (cal_busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] mkword(input int g, input int s, input int c, input logic [3:0] pad);
        logic [1:0] gv = 2'(g);
        return {gv[0], gv[1], 1'(s), 1'(c), pad};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int n;
        logic [3:0] pads [4] = '{4'h0, 4'hF, 4'h5, 4'hA};
        int prev_g, prev_s;

        wait_clk(5);
        rst = 1'b0;
        // R3: reset state with the strap high
        chk("R3 gain", gain_code, 0);
        chk("R3 sel", cfg_sel, 0);
        // R7 / R10: power-up busy length, pin pulse inside it ignored
        n = 0;
        while (cal_busy && n < 1000) begin
            n++;
            if (n == 10) cal_pin = 1'b1;
            if (n == 18) cal_pin = 1'b0;
            @(negedge clk);
        end
        chk("R7 power-up busy cycles (R10 pulse ignored)", n, PWRUP);
        wait_clk(10);
        chk("R10 no busy after ignored pulse", cal_busy, 0);

        // R1 R2 R4 R5: sweep gain, select, padding
        prev_g = 0;
        prev_s = 0;
        for (int g = 0; g < 4; g++)
            for (int s = 0; s < 2; s++)
                for (int p = 0; p < 4; p++) begin
                    spi_shift(mkword(g, s, 0, pads[p]));
                    if (p == 1) begin
                        chk("R4 gain holds before cs rise", gain_code, prev_g);
                        chk("R4 sel holds before cs rise", cfg_sel, prev_s);
                    end
                    spi_latch();
                    wait_clk(8);
                    chk("R2 R5 gain code", gain_code, g);
                    chk("R1 R5 config select", cfg_sel, s);
                    prev_g = g;
                    prev_s = s;
                end
        chk("R5 no calibration from sweep", cal_busy, 0);

        // R6: strap low
        spi_en = 1'b0;
        wait_clk(2);
        chk("R6 nv gain", gain_code, 2);
        chk("R6 nv sel", cfg_sel, 1);
        nv_gain = 2'b01;
        nv_sel  = 1'b0;
        wait_clk(1);
        chk("R6 nv gain follows", gain_code, 1);
        chk("R6 nv sel follows", cfg_sel, 0);
        spi_shift(mkword(0, 0, 1, 4'h3));
        spi_latch();
        wait_clk(8);
        chk("R6 no calibration while disabled", cal_busy, 0);
        spi_en = 1'b1;
        wait_clk(8);
        chk("R6 held gain untouched", gain_code, 3);
        chk("R6 held sel untouched", cfg_sel, 1);
        // shift register untouched: latch without shifting
        @(negedge clk);
        cs = 1'b0;
        wait_clk(HALF);
        spi_latch();
        wait_clk(8);
        chk("R6 shift reg untouched gain", gain_code, 3);
        chk("R6 shift reg untouched sel", cfg_sel, 1);

        // R8: pin trigger, R10 retrigger inside
        @(negedge clk);
        cal_pin = 1'b1;
        n = 0;
        begin
            int t = 0;
            while (!cal_busy && t < 30) begin
                @(negedge clk);
                t++;
            end
        end
        while (cal_busy && n < 1000) begin
            n++;
            if (n == 4) cal_pin = 1'b0;
            if (n == 8) cal_pin = 1'b1;
            @(negedge clk);
        end
        chk("R8 R10 pin calibration cycles", n, USER);
        wait_clk(10);
        chk("R10 held pin level starts nothing", cal_busy, 0);
        cal_pin = 1'b0;
        wait_clk(8);

        // R9: calibration bit in the word
        spi_shift(mkword(1, 0, 1, 4'h0));
        spi_latch();
        meas_busy(n);
        chk("R9 word calibration cycles", n, USER);
        chk("R9 gain with cal word", gain_code, 1);
        spi_shift(mkword(2, 1, 1, 4'h0));
        spi_latch();
        wait_clk(30);
        chk("R9 cal bit 1 over 1 no start", cal_busy, 0);
        chk("R9 fields still update", gain_code, 2);
        spi_shift(mkword(2, 1, 0, 4'h0));
        spi_latch();
        wait_clk(8);
        spi_shift(mkword(0, 0, 1, 4'h0));
        spi_latch();
        meas_busy(n);
        chk("R9 second 0-to-1 cal bit", n, USER);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule